// File: doc/BRIEF.md
# Dual-Edge Converter Output Formatter

This block takes 10-bit results from three converters and places them on a parallel output bus timed to an output pixel clock. Each converter serves two sensor channels. Converter k carries channel 2k when its select bit is 0 and channel 2k+1 when the bit is 1. A valid strobe stores the word into a per-channel holding register. The formatter then reads the holding registers in round-robin order and sends them out in one of three forms:

- a 5-bit bus that carries the upper half of a sample while the output clock is high and the lower half while it is low;
- a 10-bit bus that carries one channel while the clock is high and the next channel while it is low;
- a 10-bit bus that changes only at the falling edge.

All logic runs on the rising edge of an internal clock at twice the output rate. The output clock is a phase bit that toggles on every internal cycle. A 3-bit channel-count code selects how many channels are in use. The block decodes this code into per-channel enables and per-converter enables, so that unused processing paths can be powered down. A new width or mode setting takes effect only at a rising edge of the output clock. The two halves of one period therefore always belong to the same setting.

Top module: `adcfmt_top`

## Requirements
- R1: While reset is asserted, out_data is 0, out_clk is 0, ch_en is 6'b000001 and conv_en is 3'b001.
- R2: out_clk inverts on every internal clock cycle. It first rises at the first internal edge after reset is released.
- R3: Narrow form (cfg_wide=0) sends one channel per output period. While out_clk is high, out_data[4:0] holds sample bits [9:5]. While it is low, out_data[4:0] holds bits [4:0]. out_data[9:5] is 0 in both phases. cfg_fall_only has no effect in this form.
- R4: Dual-edge form (cfg_wide=1, cfg_fall_only=0) sends the full sample of one channel while out_clk is high and the full sample of the next enabled channel while it is low.
- R5: Falling-only form (cfg_wide=1, cfg_fall_only=1) keeps out_data unchanged at each rising edge of out_clk. It presents one new full sample at each falling edge.
- R6: Channels are served in ascending index order over the enabled set, wrapping back to the lowest enabled channel. After a change of the mode code, the first channel served is the lowest enabled channel.
- R7: The mode code decodes to these enabled channels:
  - 0: channel 0;
  - 1: channels 0 and 2;
  - 2: channels 0, 2 and 4;
  - 3: channels 0 to 3;
  - 4: all six channels.

  conv_en[k] is high exactly when channel 2k or channel 2k+1 is enabled.
- R8: Mode codes 5, 6 and 7 behave exactly like code 0.
- R9: Width and mode inputs are sampled only on the internal cycle in which out_clk is low. They take effect as out_clk rises. A change made while out_clk is high has no effect until the next rising edge of out_clk.
- R10: When conv_valid[k] is high, the block stores conv_data[10k+9:10k] into channel 2k+conv_sel[k], but only if that channel is enabled. A sample for a disabled channel is discarded, and the stored value stays as it was until a later mode makes that value visible.
- R11: Both words of an output period are fixed from the holding registers as they stand at the period's rising edge. A sample stored during the high phase appears no earlier than the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the output clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects a 10-bit bus, 0 selects a 5-bit bus |
| cfg_fall_only | input | 1 | In 10-bit form, update only at falling edges |
| cfg_mode | input | 3 | Channel-count code (see R7) |
| conv_data | input | 30 | Three 10-bit converter words, converter k at bits 10k+9:10k |
| conv_valid | input | 3 | Per-converter sample strobe |
| conv_sel | input | 3 | Per-converter channel select within its pair |
| out_clk | output | 1 | Output clock level |
| out_data | output | 10 | Output data bus |
| ch_en | output | 6 | Per-channel enable |
| conv_en | output | 3 | Per-converter enable |

## Verification
A wrong round-robin pointer or a stale holding register shows up within one output period as a wrong word on out_data. The reassembled stream then no longer matches the samples that were injected. A configuration register latched in the wrong phase shows up as a period whose two halves come from different forms. A broken phase bit shows up on out_clk at once. Discarded samples are exposed later: the mode is switched so that the previously disabled channel is read out, and the old value must appear rather than the discarded one.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  localparam int NCONV = 3;
  localparam int NCH   = 2 * NCONV;
  localparam int CW    = $clog2(NCH);
  localparam int MW    = 3;

  typedef logic [NCH-1:0] chmask_t;
  typedef logic [CW-1:0]  chidx_t;
  typedef logic [MW-1:0]  mode_t;

  localparam mode_t MODE_1CH = 3'd0;
  localparam mode_t MODE_2CH = 3'd1;
  localparam mode_t MODE_3CH = 3'd2;
  localparam mode_t MODE_4CH = 3'd3;
  localparam mode_t MODE_6CH = 3'd4;

  // enabled channel set for a mode code; unknown codes fall back to one channel
  function automatic chmask_t mode_mask(mode_t code);
    chmask_t m;
    m = '0;
    case (code)
      MODE_2CH: for (int k = 0; k < 2; k++) m[2*k] = 1'b1;
      MODE_3CH: for (int k = 0; k < NCONV; k++) m[2*k] = 1'b1;
      MODE_4CH: for (int i = 0; i < 4; i++) m[i] = 1'b1;
      MODE_6CH: m = '1;
      default:  m[0] = 1'b1;
    endcase
    return m;
  endfunction

  // lowest enabled channel
  function automatic chidx_t first_ch(chmask_t m);
    chidx_t r;
    logic   f;
    r = '0;
    f = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (m[i] && !f) begin
        r = chidx_t'(i);
        f = 1'b1;
      end
    end
    return r;
  endfunction

  // next enabled channel above cur, wrapping to the lowest
  function automatic chidx_t next_ch(chmask_t m, chidx_t cur);
    chidx_t r;
    logic   f;
    r = first_ch(m);
    f = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (m[i] && (i > int'(cur)) && !f) begin
        r = chidx_t'(i);
        f = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/adcfmt_chan_map.sv
module adcfmt_chan_map
  import adcfmt_pkg::*;
(
  input  mode_t            mode_act,
  output logic [NCH-1:0]   ch_en,
  output logic [NCONV-1:0] conv_en
);
  assign ch_en = mode_mask(mode_act);

  for (genvar k = 0; k < NCONV; k++) begin : g_conv
    assign conv_en[k] = ch_en[2*k] | ch_en[2*k+1];
  end
endmodule

// File: rtl/adcfmt_sample_hold.sv
module adcfmt_sample_hold
  import adcfmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCONV*DW-1:0] conv_data,
  input  logic [NCONV-1:0]    conv_valid,
  input  logic [NCONV-1:0]    conv_sel,
  input  logic [NCH-1:0]      ch_en,
  output logic [NCH*DW-1:0]   hold
);
  for (genvar k = 0; k < NCONV; k++) begin : g_conv
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int CH = 2 * k + s;
      logic take;
      assign take = conv_valid[k] && (conv_sel[k] == (s == 1)) && ch_en[CH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          hold[CH*DW +: DW] <= '0;
        else if (take)
          hold[CH*DW +: DW] <= conv_data[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/adcfmt_edge_seq.sv
module adcfmt_edge_seq
  import adcfmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_fall_only,
  input  mode_t             cfg_mode,
  input  logic [NCH*DW-1:0] hold,
  output logic              out_clk,
  output logic [DW-1:0]     out_data,
  output logic              act_wide,
  output logic              act_fall,
  output mode_t             act_mode
);
  localparam int HW = DW / 2;

  logic          ph;
  logic [DW-1:0] fall_word;
  chidx_t        ptr;

  chmask_t       mask_new;
  logic          mode_chg;
  logic          wide_new, fall_new;
  chidx_t        c0, c1, ptr_nxt;
  logic [DW-1:0] w0, w1;
  logic [DW-1:0] half_a, half_b;

  always_comb begin
    mask_new = mode_mask(cfg_mode);
    mode_chg = (cfg_mode != act_mode);
    wide_new = cfg_wide;
    fall_new = cfg_wide & cfg_fall_only;
    c0       = mode_chg ? first_ch(mask_new) : ptr;
    c1       = next_ch(mask_new, c0);
    w0       = hold[int'(c0)*DW +: DW];
    w1       = hold[int'(c1)*DW +: DW];
    if (!wide_new) begin
      half_a  = {{(DW-HW){1'b0}}, w0[DW-1:HW]};
      half_b  = {{(DW-HW){1'b0}}, w0[HW-1:0]};
      ptr_nxt = c1;
    end else if (!fall_new) begin
      half_a  = w0;
      half_b  = w1;
      ptr_nxt = next_ch(mask_new, c1);
    end else begin
      half_a  = out_data;
      half_b  = w0;
      ptr_nxt = c1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      out_data  <= '0;
      fall_word <= '0;
      ptr       <= '0;
      act_wide  <= 1'b0;
      act_fall  <= 1'b0;
      act_mode  <= MODE_1CH;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        act_wide  <= wide_new;
        act_fall  <= fall_new;
        act_mode  <= cfg_mode;
        out_data  <= half_a;
        fall_word <= half_b;
        ptr       <= ptr_nxt;
      end else begin
        out_data  <= fall_word;
      end
    end
  end

  assign out_clk = ph;
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top
  import adcfmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wide,
  input  logic                cfg_fall_only,
  input  logic [MW-1:0]       cfg_mode,
  input  logic [NCONV*DW-1:0] conv_data,
  input  logic [NCONV-1:0]    conv_valid,
  input  logic [NCONV-1:0]    conv_sel,
  output logic                out_clk,
  output logic [DW-1:0]       out_data,
  output logic [NCH-1:0]      ch_en,
  output logic [NCONV-1:0]    conv_en
);
  logic [NCH*DW-1:0] hold_flat;
  logic              act_wide;
  logic              act_fall;
  mode_t             act_mode;

  adcfmt_chan_map u_map (
    .mode_act (act_mode),
    .ch_en    (ch_en),
    .conv_en  (conv_en)
  );

  adcfmt_sample_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_data  (conv_data),
    .conv_valid (conv_valid),
    .conv_sel   (conv_sel),
    .ch_en      (ch_en),
    .hold       (hold_flat)
  );

  adcfmt_edge_seq #(.DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wide      (cfg_wide),
    .cfg_fall_only (cfg_fall_only),
    .cfg_mode      (cfg_mode),
    .hold          (hold_flat),
    .out_clk       (out_clk),
    .out_data      (out_data),
    .act_wide      (act_wide),
    .act_fall      (act_fall),
    .act_mode      (act_mode)
  );
endmodule

// File: rtl/adcfmt_checker.sv
module adcfmt_checker
  import adcfmt_pkg::*;
#(
  parameter int DW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_clk,
  input logic [DW-1:0]     out_data,
  input logic [NCH-1:0]    ch_en,
  input logic              act_wide,
  input logic              act_fall,
  input logic [MW-1:0]     act_mode,
  input logic [NCH*DW-1:0] hold
);
  localparam int HW = DW / 2;

  a_r2_clk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_clk != $past(out_clk)));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !act_wide |-> (out_data[DW-1:HW] == '0));

  a_r5_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wide && act_fall && $rose(out_clk)) |-> $stable(out_data));

  a_r9_cfg_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> $rose(out_clk));

  a_r7_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en[0] && ($countones(ch_en) != 5) && ($countones(ch_en) != 0));

  for (genvar i = 0; i < NCH; i++) begin : g_dis
    a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> $stable(hold[i*DW +: DW]));
  end
endmodule

bind adcfmt_top adcfmt_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_clk  (out_clk),
  .out_data (out_data),
  .ch_en    (ch_en),
  .act_wide (act_wide),
  .act_fall (act_fall),
  .act_mode (act_mode),
  .hold     (hold_flat)
);

// File: tb/tb_adcfmt_top.sv
module tb_adcfmt_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        cfg_fall_only = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [29:0] conv_data = '0;
  logic [2:0]  conv_valid = '0;
  logic [2:0]  conv_sel = '0;
  logic        out_clk;
  logic [9:0]  out_data;
  logic [5:0]  ch_en;
  logic [2:0]  conv_en;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_tag = "R6";

  adcfmt_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_fall_only(cfg_fall_only),
    .cfg_mode(cfg_mode), .conv_data(conv_data), .conv_valid(conv_valid),
    .conv_sel(conv_sel), .out_clk(out_clk), .out_data(out_data),
    .ch_en(ch_en), .conv_en(conv_en)
  );

  always #(CLK_P/2) clk = ~clk;

  // ---------------- reference model ----------------
  function automatic bit is_on(int mode, int ch);
    int n;
    case (mode)
      1: n = 2;
      2: n = 3;
      3: n = 4;
      4: n = 6;
      default: n = 1;
    endcase
    if (n <= 3) return (ch % 2 == 0) && (ch / 2 < n);
    return ch < n;
  endfunction

  function automatic int step_ch(int mode, int cur);
    for (int s = 1; s <= 6; s++) begin
      if (is_on(mode, (cur + s) % 6)) return (cur + s) % 6;
    end
    return cur;
  endfunction

  int m_ph, m_out, m_fw, m_ptr, m_mode, m_wide, m_fall;
  int m_hold[6];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_out = 0; m_fw = 0; m_ptr = 0;
      m_mode = 0; m_wide = 0; m_fall = 0;
      for (int i = 0; i < 6; i++) m_hold[i] = 0;
    end else begin
      int old_mode, a, b, md;
      old_mode = m_mode;
      if (m_ph == 0) begin
        md = int'(cfg_mode);
        a  = (md != m_mode) ? step_ch(md, 5) : m_ptr;
        b  = step_ch(md, a);
        m_wide = int'(cfg_wide);
        m_fall = int'(cfg_wide && cfg_fall_only);
        if (m_wide == 0) begin
          m_out = m_hold[a] / 32;
          m_fw  = m_hold[a] % 32;
          m_ptr = b;
        end else if (m_fall == 0) begin
          m_out = m_hold[a];
          m_fw  = m_hold[b];
          m_ptr = step_ch(md, b);
        end else begin
          m_fw  = m_hold[a];
          m_ptr = b;
        end
        m_mode = md;
      end else begin
        m_out = m_fw;
      end
      for (int k = 0; k < 3; k++) begin
        if (conv_valid[k]) begin
          int ch;
          ch = 2 * k + int'(conv_sel[k]);
          if (is_on(old_mode, ch)) m_hold[ch] = int'(conv_data[k*10 +: 10]);
        end
      end
      m_ph = 1 - m_ph;
    end
  end

  // ---------------- checks ----------------
  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int ce, cv;
    string ft;
    ce = 0; cv = 0;
    for (int i = 0; i < 6; i++) if (is_on(m_mode, i)) ce |= (1 << i);
    for (int k = 0; k < 3; k++) if (is_on(m_mode, 2*k) || is_on(m_mode, 2*k+1)) cv |= (1 << k);
    ft = (m_wide == 0) ? "R3 R6" : (m_fall == 0) ? "R4 R6" : "R5";
    check("R2", "out_clk", int'(out_clk), m_ph);
    check({ft, " ", cur_tag}, "out_data", int'(out_data), m_out);
    check((m_mode > 4) ? "R8" : "R7", "ch_en", int'(ch_en), ce);
    check((m_mode > 4) ? "R8" : "R7", "conv_en", int'(conv_en), cv);
  endtask

  task automatic rand_in(bit en);
    conv_valid = en ? 3'($urandom) : 3'b000;
    conv_sel   = 3'($urandom);
    conv_data  = 30'($urandom);
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      rand_in(rnd);
    end
  endtask

  task automatic set_cfg(bit w, bit f, int md);
    cfg_wide = w; cfg_fall_only = f; cfg_mode = 3'(md);
  endtask

  task automatic put(int conv, bit sel, int val);
    @(negedge clk);
    compare_all();
    conv_valid = '0;
    conv_valid[conv] = 1'b1;
    conv_sel[conv] = sel;
    conv_data[conv*10 +: 10] = 10'(val);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_data", int'(out_data), 0);
    check("R1", "out_clk", int'(out_clk), 0);
    check("R1", "ch_en", int'(ch_en), 1);
    check("R1", "conv_en", int'(conv_en), 1);
    rst_n = 1'b1;

    // forms x all mode codes, odd lengths move config changes into both phases (R9)
    cur_tag = "R9";
    for (int form = 0; form < 4; form++) begin
      for (int md = 0; md < 8; md++) begin
        set_cfg(form >= 2, form == 1 || form == 3, md);
        run(36 + md, 1'b1);
      end
    end

    // R10: discarded sample for disabled channel 3 must not replace stored value
    cur_tag = "R10";
    set_cfg(1'b1, 1'b0, 4);
    run(4, 1'b0);
    put(1, 1'b1, 10'h111);
    set_cfg(1'b0, 1'b0, 0);
    run(4, 1'b0);
    put(1, 1'b1, 10'h2AA);
    run(3, 1'b0);
    set_cfg(1'b1, 1'b0, 4);
    run(16, 1'b0);

    // R11: sample stored during the high phase waits for the next period
    cur_tag = "R11";
    set_cfg(1'b1, 1'b1, 0);
    run(5, 1'b0);
    for (int j = 0; j < 8; j++) begin
      put(0, 1'b0, 10'h0F0 + j);
      run(1 + j % 2, 1'b0);
    end
    run(6, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule